// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block sequences a microcontroller through four power modes: Active, Power Save, Idle and Halt. Software asks for a lower-power mode by writing request bits into a control register. A gating bit in the same register selects whether the request acts at once or waits for the CPU to signal that it is executing a WAIT instruction. Hardware returns the device to Active. A wake-up input or a non-maskable interrupt sets a pending latch. The latch holds until the interrupt controller acknowledges it. The controller restores clocking when it returns to Active, but it does not start program execution.

Every mode change is qualified by stability inputs from the clock sources. Leaving Active needs a stable low-frequency oscillator. Entering Active needs a stable high-frequency oscillator and a PLL that is either locked or powered down. The block drives disable outputs for the high-frequency oscillator and the PLL. In Power Save and Idle, each of these disables can also follow the sleep state of an external radio link controller, through a hardware clock-control bit that clears itself on return to Active. A status byte reports the live stability flags and the two hardware clock-control bits.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the mode is Active (code 0), the control readback is 0x00, the wake-pending output is 0, both disable outputs are 0 and status bits 7..3 are 0.
- R2: Control register bits are: bit0 power-save request, bit1 idle request, bit2 halt request, bit3 wait gate, bit4 oscillator disable, bit5 PLL disable, bit6 PLL power-down; bit7 reads 0. With the wait gate at 0 and the low-frequency oscillator stable, a set power-save request moves Active to Power Save (code 1) on the clock edge after the register holds it. Idle and halt requests have no effect while the wait gate is 0.
- R3: With the wait gate at 1, no low-power mode is entered unless the WAIT input is high. On a cycle with WAIT high the order of precedence is halt (code 3), then idle (code 2), then power save (code 1).
- R4: While the low-frequency oscillator stable input is 0, the mode never leaves Active.
- R5: A wake-up or NMI pulse sets the wake-pending latch on the next edge. The latch holds until an acknowledge, and a new event in the same cycle as an acknowledge wins.
- R6: In a low-power mode with wake pending, the mode becomes Active on the first edge at which the oscillator is stable and the PLL is ready. Until then the mode and the pending latch stay as they are.
- R7: The PLL counts as ready when its lock input is 1 or when the PLL disable output is 1.
- R8: The oscillator disable output is 0 in Active and 1 in Halt. In Power Save and Idle it is the disable bit ORed with (hardware oscillator control AND link sleep).
- R9: The PLL disable output equals the power-down bit in Active and is 1 in Halt. In Power Save and Idle it is the PLL disable bit OR the power-down bit OR (hardware PLL control AND link sleep).
- R10: On entry to Active the three request bits and both hardware clock-control bits clear. All other control bits are kept.
- R11: The status byte is {000, hardware PLL control, hardware oscillator control, PLL ready, oscillator stable, low-frequency stable}, with bit 0 the low-frequency flag. A write with select 1 loads the two hardware control bits from data bits 3 (oscillator) and 4 (PLL).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 the hardware clock-control bits |
| reg_wdata | input | 8 | Write data |
| wait_exec | input | 1 | CPU is executing WAIT |
| wake_evt | input | 1 | Maskable wake-up event |
| nmi_evt | input | 1 | Non-maskable interrupt event |
| int_ack | input | 1 | Interrupt acknowledge, clears pending wake |
| lfo_stable | input | 1 | Low-frequency oscillator stable |
| hfo_stable | input | 1 | High-frequency oscillator stable |
| pll_lock | input | 1 | PLL locked |
| link_sleep | input | 1 | Link controller is asleep |
| mode | output | 2 | Current mode: 0 Active, 1 Power Save, 2 Idle, 3 Halt |
| hfo_off | output | 1 | High-frequency oscillator disable |
| pll_off | output | 1 | PLL disable |
| wake_pending | output | 1 | Latched wake event |
| ctl_rdata | output | 8 | Control register readback |
| status | output | 8 | Status byte |

## Verification
The assertions check several properties on every cycle. The mode holds in Active while the low-frequency flag is low. A low-power mode holds while the oscillator or the PLL is not ready. A ready pending wake always leads to Active on the next edge. The pending latch sets on an event and holds until an acknowledge. The clearing on Active entry is checked the same way. The bench's sweeps show what the assertions cannot: the precedence among the halt, idle and power-save requests, the register bits that survive Active entry, and the full truth tables of both disable outputs and the PLL-ready status bit.

// File: rtl/pwr_mode_pkg.sv
// Package: shared types and field positions for the power mode controller.
// Assumes an 8-bit register width; field positions are fixed by the brief.
package pwr_mode_pkg;
    localparam int REG_W  = 8;
    localparam int MODE_W = 2;
    localparam int HW_W   = 2;

    localparam int B_PSV   = 0;
    localparam int B_IDLE  = 1;
    localparam int B_HALT  = 2;
    localparam int B_GATE  = 3;
    localparam int B_HDIS  = 4;
    localparam int B_PDIS  = 5;
    localparam int B_PWDN  = 6;
    localparam int REQ_W   = B_HALT + 1;
    localparam int HW_LSB  = 3;

    typedef enum logic [MODE_W-1:0] {
        M_ACTIVE = 2'd0,
        M_PSAVE  = 2'd1,
        M_IDLE   = 2'd2,
        M_HALT   = 2'd3
    } pmode_t;
endpackage

// File: rtl/pwr_wake_latch.sv
// Module: holds a wake event (maskable or NMI) until acknowledged.
// Assumes events and acknowledge are single-clock-domain pulses; set wins over clear.
module pwr_wake_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_evt,
    input  logic nmi_evt,
    input  logic int_ack,
    output logic pend
);
    logic set_w;
    assign set_w = wake_evt | nmi_evt;

    // Latch a wake event; an acknowledge clears it unless a new event arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (set_w)  pend <= 1'b1;
        else if (int_ack) pend <= 1'b0;
    end

    // R5
    wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_w |=> pend);
    // R5
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !int_ack) |=> pend);
endmodule

// File: rtl/pwr_ctl_regs.sv
// Module: control register and hardware clock-control bits.
// Assumes enter_active marks the edge on which the mode returns to Active;
// that clearing outranks a same-cycle write.
module pwr_ctl_regs
    import pwr_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             enter_active,
    output logic [REG_W-1:0] ctl_q,
    output logic [HW_W-1:0]  hw_q
);
    localparam logic [REG_W-1:0] CTL_MASK = REG_W'((1 << (B_PWDN + 1)) - 1);

    // Register writes plus the automatic clear on return to Active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            hw_q  <= '0;
        end else begin
            if (reg_wr && !reg_sel) ctl_q <= reg_wdata & CTL_MASK;
            if (reg_wr && reg_sel)  hw_q  <= reg_wdata[HW_LSB +: HW_W];
            if (enter_active) begin
                ctl_q[REQ_W-1:0] <= '0;
                hw_q             <= '0;
            end
        end
    end

    // R10
    active_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_active |=> (ctl_q[REQ_W-1:0] == '0 && hw_q == '0));
endmodule

// File: rtl/pwr_mode_fsm.sv
// Module: mode state machine with stability-qualified transitions.
// Assumes pll_ok already folds in the PLL power-down condition.
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   psv_req,
    input  logic   idle_req,
    input  logic   halt_req,
    input  logic   wait_gate,
    input  logic   wait_exec,
    input  logic   lfo_stable,
    input  logic   hfo_stable,
    input  logic   pll_ok,
    input  logic   pend,
    output pmode_t mode_q,
    output logic   enter_active
);
    pmode_t mode_d;

    // Next-mode selection: low-power entry from Active, wake back to Active.
    always_comb begin
        mode_d       = mode_q;
        enter_active = 1'b0;
        if (mode_q == M_ACTIVE) begin
            if (lfo_stable) begin
                if (!wait_gate) begin
                    if (psv_req) mode_d = M_PSAVE;
                end else if (wait_exec) begin
                    if (halt_req)      mode_d = M_HALT;
                    else if (idle_req) mode_d = M_IDLE;
                    else if (psv_req)  mode_d = M_PSAVE;
                end
            end
        end else if (pend && hfo_stable && pll_ok) begin
            mode_d       = M_ACTIVE;
            enter_active = 1'b1;
        end
    end

    // Mode state register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= M_ACTIVE;
        else        mode_q <= mode_d;
    end

    // R4
    lfo_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_ACTIVE && !lfo_stable) |=> mode_q == M_ACTIVE);
    // R2
    no_req_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_ACTIVE && !wait_gate && !psv_req) |=> mode_q == M_ACTIVE);
    // R3
    wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_ACTIVE && wait_gate && !wait_exec) |=> mode_q == M_ACTIVE);
    // R6
    wake_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != M_ACTIVE && (!hfo_stable || !pll_ok)) |=> mode_q != M_ACTIVE);
    // R6
    wake_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != M_ACTIVE && pend && hfo_stable && pll_ok) |=> mode_q == M_ACTIVE);
endmodule

// File: rtl/pwr_clk_gate.sv
// Module: combinational oscillator and PLL disable decode plus PLL-ready flag.
// Assumes Halt stops both sources and Active keeps the oscillator running.
module pwr_clk_gate
    import pwr_mode_pkg::*;
(
    input  pmode_t mode_q,
    input  logic   hfo_dis,
    input  logic   pll_dis,
    input  logic   pll_pwdn,
    input  logic   hw_hfo,
    input  logic   hw_pll,
    input  logic   link_sleep,
    input  logic   pll_lock,
    output logic   hfo_off,
    output logic   pll_off,
    output logic   pll_ok
);
    // Disable decode per mode.
    always_comb begin
        case (mode_q)
            M_PSAVE, M_IDLE: begin
                hfo_off = hfo_dis | (hw_hfo & link_sleep);
                pll_off = pll_dis | pll_pwdn | (hw_pll & link_sleep);
            end
            M_HALT: begin
                hfo_off = 1'b1;
                pll_off = 1'b1;
            end
            default: begin
                hfo_off = 1'b0;
                pll_off = pll_pwdn;
            end
        endcase
    end

    // A disabled PLL never blocks a transition.
    assign pll_ok = pll_lock | pll_off;
endmodule

// File: rtl/pwr_mode_ctl.sv
// Module: top of the low-power mode sequencer; wires registers, wake latch,
// state machine and clock gating, and forms the status byte.
// Assumes all inputs are synchronous to clk.
module pwr_mode_ctl
    import pwr_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             wait_exec,
    input  logic             wake_evt,
    input  logic             nmi_evt,
    input  logic             int_ack,
    input  logic             lfo_stable,
    input  logic             hfo_stable,
    input  logic             pll_lock,
    input  logic             link_sleep,
    output logic [MODE_W-1:0] mode,
    output logic             hfo_off,
    output logic             pll_off,
    output logic             wake_pending,
    output logic [REG_W-1:0] ctl_rdata,
    output logic [REG_W-1:0] status
);
    logic [REG_W-1:0] ctl_q;
    logic [HW_W-1:0]  hw_q;
    logic             enter_active;
    logic             pll_ok;
    pmode_t           mode_q;

    pwr_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .enter_active(enter_active),
        .ctl_q(ctl_q), .hw_q(hw_q)
    );

    pwr_wake_latch u_wake (
        .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .nmi_evt(nmi_evt),
        .int_ack(int_ack), .pend(wake_pending)
    );

    pwr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .psv_req(ctl_q[B_PSV]), .idle_req(ctl_q[B_IDLE]), .halt_req(ctl_q[B_HALT]),
        .wait_gate(ctl_q[B_GATE]), .wait_exec(wait_exec),
        .lfo_stable(lfo_stable), .hfo_stable(hfo_stable), .pll_ok(pll_ok),
        .pend(wake_pending), .mode_q(mode_q), .enter_active(enter_active)
    );

    pwr_clk_gate u_gate (
        .mode_q(mode_q), .hfo_dis(ctl_q[B_HDIS]), .pll_dis(ctl_q[B_PDIS]),
        .pll_pwdn(ctl_q[B_PWDN]), .hw_hfo(hw_q[0]), .hw_pll(hw_q[1]),
        .link_sleep(link_sleep), .pll_lock(pll_lock),
        .hfo_off(hfo_off), .pll_off(pll_off), .pll_ok(pll_ok)
    );

    assign mode      = mode_q;
    assign ctl_rdata = ctl_q;
    assign status    = {{(REG_W-HW_LSB-HW_W){1'b0}}, hw_q, pll_ok, hfo_stable, lfo_stable};

    // R8
    halt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_HALT) |-> (hfo_off && pll_off));
endmodule

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_sel = 0, wait_exec = 0, wake_evt = 0, nmi_evt = 0, int_ack = 0;
    logic lfo_stable = 1, hfo_stable = 1, pll_lock = 1, link_sleep = 0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] mode;
    logic hfo_off, pll_off, wake_pending;
    logic [7:0] ctl_rdata, status;
    int n_chk = 0, n_fail = 0;

    pwr_mode_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .wait_exec(wait_exec), .wake_evt(wake_evt), .nmi_evt(nmi_evt), .int_ack(int_ack),
        .lfo_stable(lfo_stable), .hfo_stable(hfo_stable), .pll_lock(pll_lock),
        .link_sleep(link_sleep), .mode(mode), .hfo_off(hfo_off), .pll_off(pll_off),
        .wake_pending(wake_pending), .ctl_rdata(ctl_rdata), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic wake_up();
        hfo_stable = 1; pll_lock = 1; wake_evt = 1;
        cyc(1);
        wake_evt = 0;
        cyc(2);
        int_ack = 1;
        cyc(1);
        int_ack = 0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 mode", {6'b0, mode}, 8'h0);
        chk("R1 ctl", ctl_rdata, 8'h00);
        chk("R1 status upper", {3'b0, status[7:3]}, 8'h0);
        chk("R1 pending", {7'b0, wake_pending}, 8'h0);
        chk("R1 offs", {6'b0, hfo_off, pll_off}, 8'h0);

        // R7 R11 status sweep in Active
        for (int i = 0; i < 16; i++) begin
            lfo_stable = i[0]; hfo_stable = i[1]; pll_lock = i[2];
            wr_reg(0, {1'b0, i[3], 6'b0});
            #1 chk("R7 R11 status", status,
                   {5'b0, logic'(i[2] | i[3]), logic'(i[1]), logic'(i[0])});
            chk("R9 active pll_off", {7'b0, pll_off}, {7'b0, logic'(i[3])});
        end
        wr_reg(0, 8'h00);
        hfo_stable = 1; pll_lock = 1;

        // R2 R3 R4 R10 entry sweep
        for (int i = 0; i < 64; i++) begin
            logic [3:0] c;
            logic [1:0] exp;
            c = i[3:0];
            lfo_stable = i[4];
            wr_reg(0, {4'b0, c});
            wait_exec = i[5];
            cyc(1);
            wait_exec = 0;
            exp = 2'd0;
            if (i[4]) begin
                if (!c[3]) exp = c[0] ? 2'd1 : 2'd0;
                else if (i[5]) exp = c[2] ? 2'd3 : c[1] ? 2'd2 : c[0] ? 2'd1 : 2'd0;
            end
            chk("R2 R3 R4 mode", {6'b0, mode}, {6'b0, exp});
            if (exp == 2'd3) chk("R8 R9 halt offs", {6'b0, hfo_off, pll_off}, 8'h03);
            if (exp != 2'd0) begin
                lfo_stable = 1;
                wake_up();
                chk("R6 back active", {6'b0, mode}, 8'h0);
                chk("R10 req clear", ctl_rdata, {4'b0, c[3], 3'b0});
            end
            wr_reg(0, 8'h00);
        end
        lfo_stable = 1;

        // R6 R7 wake blocking sweep from Power Save
        for (int i = 0; i < 8; i++) begin
            logic ok;
            wr_reg(0, {1'b0, i[2], 6'h01});
            cyc(1);
            chk("R2 psave entry", {6'b0, mode}, 8'h1);
            hfo_stable = i[0]; pll_lock = i[1];
            wake_evt = 1;
            cyc(1);
            wake_evt = 0;
            cyc(3);
            ok = i[0] & (i[1] | i[2]);
            chk("R6 R7 wake gate", {6'b0, mode}, ok ? 8'h0 : 8'h1);
            chk("R5 R6 pending held", {7'b0, wake_pending}, 8'h1);
            if (!ok) begin
                hfo_stable = 1; pll_lock = 1;
                cyc(1);
                chk("R6 first ready edge", {6'b0, mode}, 8'h0);
            end
            int_ack = 1; cyc(1); int_ack = 0;
            wr_reg(0, 8'h00);
        end

        // R5 latch behaviour
        nmi_evt = 1; cyc(1); nmi_evt = 0; cyc(3);
        chk("R5 nmi held", {7'b0, wake_pending}, 8'h1);
        int_ack = 1; cyc(1); int_ack = 0;
        chk("R5 ack clears", {7'b0, wake_pending}, 8'h0);
        nmi_evt = 1; int_ack = 1; cyc(1); nmi_evt = 0; int_ack = 0;
        chk("R5 set wins", {7'b0, wake_pending}, 8'h1);
        int_ack = 1; cyc(1); int_ack = 0;
        chk("R5 ack clears again", {7'b0, wake_pending}, 8'h0);

        // R8 R9 disable sweep in Idle
        wr_reg(0, 8'h0A);
        wait_exec = 1; cyc(1); wait_exec = 0;
        chk("R3 idle entry", {6'b0, mode}, 8'h2);
        for (int i = 0; i < 64; i++) begin
            link_sleep = i[5];
            wr_reg(0, {1'b0, i[2], i[1], i[0], 4'hA});
            wr_reg(1, {3'b0, i[4], i[3], 3'b0});
            #1;
            chk("R8 hfo_off", {7'b0, hfo_off}, {7'b0, logic'(i[0] | (i[3] & i[5]))});
            chk("R9 pll_off", {7'b0, pll_off}, {7'b0, logic'(i[1] | i[2] | (i[4] & i[5]))});
        end
        chk("R11 hw bits", {6'b0, status[4:3]}, 8'h3);
        wake_up();
        chk("R10 hw clear", {6'b0, status[4:3]}, 8'h0);
        chk("R10 ctl after", ctl_rdata, 8'h78);
        chk("R8 active hfo_off", {7'b0, hfo_off}, 8'h0);
        chk("R9 active pll_off", {7'b0, pll_off}, 8'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule